// File: doc/BRIEF.md
# Single-Wire Humidity/Temperature Responder Emulator

This block stands in for the device end of a single-wire humidity and temperature sensor link, so that a host-side reader can be exercised without the real sensor. The shared data line is open-drain: the block senses the line level on one input and pulls it low through a drive-enable output. Everything is timed in ticks of a 1 MHz enable that runs beside a faster system clock.

After reset the block stays deaf for a power-up interval. From then on it waits for the host to hold the line low for a long start interval. When the host lets go, the block answers with a low/high acknowledge pair. It then sends a 40-bit frame, most significant bit first. The frame is built from two byte inputs, humidity and temperature. Two reserved bytes are sent as zero, and the last byte is a generated checksum. The inputs are captured once, when a valid start is recognised. A short low marker closes the transfer and the line is released to idle.

Top module: `humtemp_responder`

## Requirements
- R1: For POWERUP_US ticks after reset, line activity is ignored and `drive_low` stays 0. A start pulse that ends inside this interval never produces a response.
- R2: A start is recognised only when the line has been low for at least START_MIN_US consecutive ticks and is then seen high. A shorter low pulse produces no response.
- R3: After the host releases the line at the end of a valid start, the block begins driving low 20 to 40 µs later (RESP_DELAY_US ticks, plus a few clocks of synchronisation).
- R4: The acknowledge is ACK_LOW_US ticks of `drive_low`=1 followed by ACK_HIGH_US ticks of `drive_low`=0.
- R5: Each data bit is BIT_LOW_US ticks low followed by a released phase. That phase lasts ZERO_HIGH_US ticks for a 0 and ONE_HIGH_US ticks for a 1. All phase boundaries fall on tick cycles.
- R6: A frame has exactly 40 bits, sent MSB first. Byte order: humidity (bits 39:32), reserved (31:24), temperature (23:16), reserved (15:8), checksum (7:0).
- R7: The checksum byte equals the low 8 bits of the sum of the four preceding bytes.
- R8: Both reserved bytes are transmitted as 0x00.
- R9: After the last bit the block drives an END_LOW_US-tick low marker and then keeps the line released until the next valid start.
- R10: `hum_int` and `temp_int` are sampled when the start is recognised. Changes to them during a transfer do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-clock enable at 1 MHz; all timing counts these |
| line_in | input | 1 | Sensed level of the shared data line |
| hum_int | input | BYTE_W | Humidity byte to report |
| temp_int | input | BYTE_W | Temperature byte to report |
| drive_low | output | 1 | 1 pulls the open-drain line low; 0 releases it |

## Verification
The assertions assume that `tick_1us` is a single-cycle enable and that the host never pulls the line low while the block is transmitting. Under those conditions, low phases stay bounded and the bit index stays inside the frame. The bench keeps to this: it drives the host side only during its own start pulse and then waits for the block's closing marker and idle period. It generates the tick as a strict every-other-clock enable. Random byte values and random start lengths are drawn only above the start threshold, except for the deliberate short-pulse and blackout cases.

// File: rtl/hts_pkg.sv
// Shared types and helpers for the single-wire responder emulator.
// Assumes nothing beyond elaboration-time constant arguments.
package hts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_END_LO
    } phase_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic pulls_low(input phase_t p);
        return (p == ST_ACK_LO) || (p == ST_BIT_LO) || (p == ST_END_LO);
    endfunction

endpackage

// File: rtl/hts_blackout.sv
// Power-up blackout timer: raises ready after POWERUP_US ticks following
// reset and keeps it high until the next reset. Assumes tick is a 1-clock enable.
module hts_blackout #(
    parameter int unsigned POWERUP_US = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic ready
);
    localparam int unsigned CW = $clog2(POWERUP_US + 1);

    logic [CW-1:0] cnt;

    // Count ticks until the blackout has elapsed, then hold ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (!ready && tick) begin
            if (cnt == CW'(POWERUP_US - 1)) ready <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hts_start_detect.sv
// Host start detector: synchronises the line and counts consecutive low ticks
// while armed. It pulses start_ok for one clock when the line returns high
// after at least START_MIN_US low ticks. Assumes line_in is asynchronous.
module hts_start_detect #(
    parameter int unsigned START_MIN_US = 18_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic armed,
    input  logic line_in,
    output logic start_ok
);
    localparam int unsigned LW = $clog2(START_MIN_US + 1);

    logic [1:0]    sync_q;
    logic          line_s;
    logic [LW-1:0] low_cnt;

    assign line_s = sync_q[1];

    // Two-flop synchroniser; the line idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_in};
    end

    // Saturating low-run counter and start qualification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            start_ok <= 1'b0;
        end else begin
            start_ok <= 1'b0;
            if (!armed) begin
                low_cnt <= '0;
            end else if (tick) begin
                if (!line_s) begin
                    if (low_cnt != LW'(START_MIN_US)) low_cnt <= low_cnt + 1'b1;
                end else begin
                    if (low_cnt == LW'(START_MIN_US)) start_ok <= 1'b1;
                    low_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/hts_frame.sv
// Frame register: on load it captures humidity, a zero byte, temperature,
// a zero byte and the modulo-256 byte sum. It shifts left by one bit on each
// shift. The top bit is the bit on air. Assumes load and shift are never both set.
module hts_frame #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  shift,
    input  logic [BYTE_W-1:0]     hum,
    input  logic [BYTE_W-1:0]     temp,
    output logic [5*BYTE_W-1:0]   frame_q
);
    localparam int unsigned NBYTES = 5;
    localparam int unsigned FW     = NBYTES * BYTE_W;

    logic [BYTE_W-1:0] bytes [NBYTES];
    logic [FW-1:0]     packed_w;

    // Assemble byte lanes: data and reserved bytes, then the checksum.
    always_comb begin
        bytes[0] = hum;
        bytes[1] = '0;
        bytes[2] = temp;
        bytes[3] = '0;
        bytes[4] = BYTE_W'(hum + temp);
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign packed_w[FW-1-g*BYTE_W -: BYTE_W] = bytes[g];
    end

    // Capture at transaction start, shift MSB-first per sent bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     frame_q <= '0;
        else if (load)  frame_q <= packed_w;
        else if (shift) frame_q <= {frame_q[FW-2:0], 1'b0};
    end
endmodule

// File: rtl/humtemp_responder.sv
// Device-side emulator of a single-wire humidity/temperature link. It runs the
// phase sequencer (wait, acknowledge, 40 bits, end marker) on 1 MHz ticks and
// drives an open-drain enable. Assumes the host stays off the line while the
// block transmits.
module humtemp_responder
    import hts_pkg::*;
#(
    parameter int unsigned POWERUP_US     = 1_000_000,
    parameter int unsigned START_MIN_US   = 18_000,
    parameter int unsigned RESP_DELAY_US  = 30,
    parameter int unsigned ACK_LOW_US     = 80,
    parameter int unsigned ACK_HIGH_US    = 80,
    parameter int unsigned BIT_LOW_US     = 50,
    parameter int unsigned ZERO_HIGH_US   = 27,
    parameter int unsigned ONE_HIGH_US    = 70,
    parameter int unsigned END_LOW_US     = 50,
    parameter int unsigned BYTE_W         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              line_in,
    input  logic [BYTE_W-1:0] hum_int,
    input  logic [BYTE_W-1:0] temp_int,
    output logic              drive_low
);
    localparam int unsigned FRAME_W     = 5 * BYTE_W;
    localparam int unsigned IDX_W       = $clog2(FRAME_W);
    localparam int unsigned LONGEST_LOW = umax(ACK_LOW_US, umax(BIT_LOW_US, END_LOW_US));
    localparam int unsigned LONGEST     = umax(LONGEST_LOW,
                                          umax(umax(RESP_DELAY_US, ACK_HIGH_US),
                                               umax(ZERO_HIGH_US, ONE_HIGH_US)));
    localparam int unsigned TMR_W       = $clog2(LONGEST + 1);

    phase_t             state, state_n;
    logic [TMR_W-1:0]   tmr, phase_len;
    logic [IDX_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] frame_q;
    logic               ready, start_ok, armed;
    logic               phase_done, load, shift, drive_q;

    assign armed     = ready && (state == ST_IDLE);
    assign load      = (state == ST_IDLE) && start_ok;
    assign shift     = (state == ST_BIT_HI) && phase_done;
    assign drive_low = drive_q;

    hts_blackout #(.POWERUP_US(POWERUP_US)) u_blackout (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1us),
        .ready (ready)
    );

    hts_start_detect #(.START_MIN_US(START_MIN_US)) u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1us),
        .armed    (armed),
        .line_in  (line_in),
        .start_ok (start_ok)
    );

    hts_frame #(.BYTE_W(BYTE_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .hum     (hum_int),
        .temp    (temp_int),
        .frame_q (frame_q)
    );

    // Length in ticks of the current phase; bit-high length follows the bit on air.
    always_comb begin
        unique case (state)
            ST_WAIT:   phase_len = TMR_W'(RESP_DELAY_US);
            ST_ACK_LO: phase_len = TMR_W'(ACK_LOW_US);
            ST_ACK_HI: phase_len = TMR_W'(ACK_HIGH_US);
            ST_BIT_LO: phase_len = TMR_W'(BIT_LOW_US);
            ST_BIT_HI: phase_len = frame_q[FRAME_W-1] ? TMR_W'(ONE_HIGH_US)
                                                      : TMR_W'(ZERO_HIGH_US);
            ST_END_LO: phase_len = TMR_W'(END_LOW_US);
            default:   phase_len = '0;
        endcase
    end

    assign phase_done = tick_1us && (state != ST_IDLE) && (tmr == phase_len - TMR_W'(1));

    // Next phase of the transaction sequencer.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start_ok)   state_n = ST_WAIT;
            ST_WAIT:   if (phase_done) state_n = ST_ACK_LO;
            ST_ACK_LO: if (phase_done) state_n = ST_ACK_HI;
            ST_ACK_HI: if (phase_done) state_n = ST_BIT_LO;
            ST_BIT_LO: if (phase_done) state_n = ST_BIT_HI;
            ST_BIT_HI: if (phase_done) state_n = (bit_idx == IDX_W'(FRAME_W - 1))
                                                 ? ST_END_LO : ST_BIT_LO;
            ST_END_LO: if (phase_done) state_n = ST_IDLE;
            default:                   state_n = ST_IDLE;
        endcase
    end

    // Phase register, tick timer, bit index and registered line drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            bit_idx <= '0;
            drive_q <= 1'b0;
        end else begin
            state   <= state_n;
            drive_q <= pulls_low(state_n);
            if (state_n != state)                 tmr <= '0;
            else if (tick_1us && state != ST_IDLE) tmr <= tmr + 1'b1;
            if (load)                                             bit_idx <= '0;
            else if (shift && bit_idx != IDX_W'(FRAME_W - 1))    bit_idx <= bit_idx + 1'b1;
        end
    end
endmodule

// File: rtl/hts_checker.sv
// Assertion checker bound to humtemp_responder. It assumes tick is a one-clock
// enable and that the host stays off the line during a transfer.
module hts_checker #(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned LONGEST_LOW = 80
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  ready,
    input logic                  start_ok,
    input logic                  drive_low,
    input logic                  load,
    input logic [5*BYTE_W-1:0]   frame,
    input logic [$clog2(5*BYTE_W)-1:0] bit_idx
);
    localparam int unsigned FRAME_W = 5 * BYTE_W;
    localparam int unsigned LW      = $clog2(LONGEST_LOW + 2);

    logic [LW-1:0] low_ticks;

    // Ticks seen so far in the current low run of the line drive.
    always_ff @(posedge clk) begin
        if (!rst_n || !drive_low) low_ticks <= '0;
        else if (tick)            low_ticks <= low_ticks + 1'b1;
    end

    AST_BLACKOUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !drive_low); // R1
    AST_NO_EARLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !start_ok); // R1
    AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_low && tick) |-> (low_ticks < LW'(LONGEST_LOW))); // R4
    AST_TICK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(drive_low)); // R5
    AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx < ($clog2(FRAME_W))'(FRAME_W)); // R6
    AST_SUM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (frame[BYTE_W-1:0] ==
                  BYTE_W'(frame[4*BYTE_W +: BYTE_W] + frame[2*BYTE_W +: BYTE_W]))); // R7
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (frame[3*BYTE_W +: BYTE_W] == '0 && frame[BYTE_W +: BYTE_W] == '0)); // R8
endmodule

bind humtemp_responder hts_checker #(
    .BYTE_W      (BYTE_W),
    .LONGEST_LOW (LONGEST_LOW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1us),
    .ready     (ready),
    .start_ok  (start_ok),
    .drive_low (drive_low),
    .load      (load),
    .frame     (frame_q),
    .bit_idx   (bit_idx)
);

// File: tb/humtemp_responder_tb.sv
`timescale 1ns/1ps
module humtemp_responder_tb;
    localparam int PWR   = 2000;
    localparam int SMIN  = 300;
    localparam int CPT   = 2;            // clocks per tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       host_low = 1'b0;
    logic [7:0] hum = 8'h00, temp = 8'h00;
    logic       drive_low, line_in;
    int         checks = 0, errors = 0;

    assign line_in = !(host_low || drive_low);

    always #4 clk = ~clk;

    humtemp_responder #(.POWERUP_US(PWR), .START_MIN_US(SMIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick), .line_in(line_in),
        .hum_int(hum), .temp_int(temp), .drive_low(drive_low)
    );

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    function automatic logic [39:0] exp_frame(input logic [7:0] h, input logic [7:0] t);
        logic [7:0] s;
        s = h + t;
        return {h, 8'h00, t, 8'h00, s};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_len(input logic lvl, input int cap, output int n);
        n = 0;
        while (drive_low === lvl && n < cap) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic host_pulse(input int clks);
        host_low = 1'b1;
        repeat (clks) @(negedge clk);
        host_low = 1'b0;
    endtask

    task automatic do_txn(input logic [7:0] h, input logic [7:0] t, input int low_clks,
                          input bit mid_change);
        logic [39:0] got, expv;
        int n;
        got = '0;
        expv = exp_frame(h, t);
        hum = h; temp = t;
        host_pulse(low_clks);
        if (mid_change) fork
            begin
                repeat (1200) @(negedge clk);
                hum = ~h; temp = h ^ 8'h3C;
            end
        join_none
        run_len(1'b0, 2000, n);
        chk(n >= 40 && n <= 80, "R3 response delay", n, 60);
        run_len(1'b1, 2000, n);
        chk(n == 80 * CPT, "R4 ack low", n, 80 * CPT);
        run_len(1'b0, 2000, n);
        chk(n == 80 * CPT, "R4 ack high", n, 80 * CPT);
        for (int i = 0; i < 40; i++) begin
            run_len(1'b1, 2000, n);
            chk(n == 50 * CPT, "R5 bit low", n, 50 * CPT);
            run_len(1'b0, 2000, n);
            chk(n == 27 * CPT || n == 70 * CPT, "R5 bit high", n, expv[39 - i] ? 70 * CPT : 27 * CPT);
            got = {got[38:0], n == 70 * CPT};
        end
        run_len(1'b1, 2000, n);
        chk(n == 50 * CPT, "R9 end marker", n, 50 * CPT);
        run_len(1'b0, 300, n);
        chk(n == 300, "R9 idle release", n, 300);
        chk(got[39:32] == h && got[23:16] == t, "R6 byte order", got[39:16], expv[39:16]);
        chk(got[31:24] == 8'h00 && got[15:8] == 8'h00, "R8 reserved", got[31:8], 0);
        chk(got[7:0] == 8'(h + t), "R7 checksum", got[7:0], expv[7:0]);
        if (mid_change) chk(got == expv, "R10 captured inputs", got, expv);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(drive_low == 1'b0, "R1 reset released", drive_low, 0);
        rst_n = 1'b1;
        // R1: valid-length start inside the blackout is ignored.
        host_pulse(1000);
        run_len(1'b0, 600, n);
        chk(n == 600, "R1 blackout ignore", n, 600);
        repeat (3000) @(negedge clk);
        // R2: too-short start produces no response.
        host_pulse(SMIN * CPT - 100);
        run_len(1'b0, 600, n);
        chk(n == 600, "R2 short pulse ignored", n, 600);
        // Directed corner cases: near-minimum start, checksum wraparound.
        do_txn(8'h00, 8'h00, SMIN * CPT + 40, 1'b0);
        do_txn(8'hFF, 8'hFF, SMIN * CPT + 100, 1'b0);
        do_txn(8'h80, 8'h80, SMIN * CPT + 60, 1'b0);
        // R10: inputs change mid-transfer.
        do_txn(8'hA5, 8'h1E, SMIN * CPT + 80, 1'b1);
        // Random bytes and start lengths.
        for (int k = 0; k < 6; k++) begin
            do_txn(8'($urandom), 8'($urandom), SMIN * CPT + 40 + int'($urandom % 200), 1'b0);
        end
        finish_run();
    end
endmodule